// File: doc/BRIEF.md
# Guarded Two-Stage Watchdog Timer

This block is a watchdog peripheral behind a small word-wide register port with byte strobes. Once enabled, it counts down a first interval taken from one preload register. If software does not send a keep-alive before that interval ends, the block raises a timeout flag and can invert a notification pin. It then starts a second interval from another preload register. If the flag is still set when the second interval ends, the block drives a multi-cycle reset request on either a warm or a cold reset output.

The two preload registers and the keep-alive byte are guarded. Each write to them is accepted only when it directly follows a two-byte key written to the low byte of the keep-alive word. Each key unlocks one guarded write. A sticky lock bit freezes the enable and the configuration until the block's own reset.

Each stage counts in units of prescaler periods. A unit is 2^UNIT_LOG2 clocks, or 2^FAST_LOG2 clocks when the short range is selected. A stage lasts (preload + 1) units.

Top module: `lockwd_timer`

## Requirements
- R1: After reset, every register reads zero, the key is not armed, and the flag, notification pin and both reset outputs are low.
- R2: A write to word 0x00 (first preload), to word 0x04 (second preload), or to byte lane 1 of word 0x0C (keep-alive byte) takes effect only if the two writes before it were lane-0-only writes of 0x80 and then 0x86 to word 0x0C. Otherwise the write is ignored.
- R3: One key unlocks exactly one guarded write. Any other write clears a partial or complete key, except that a 0x80 key byte always starts a new key.
- R4: The preload registers store and read back all 32 bits, and each byte strobe updates one byte. Only the low PRE_W bits load the counter.
- R5: The first stage starts when the timer is enabled or on a keep-alive. It lasts (preload1 + 1) × 2^UNIT_LOG2 clocks. Word 0x14 reads the current stage count.
- R6: When the first stage expires, the flag sets (port, and bit 9 of word 0x0C). The notification pin inverts unless configuration bit 5 is set. The second stage loads preload 2.
- R7: When the second stage expires with the flag set and configuration bit 4 set, a pulse of RST_LEN clocks appears on the warm reset output if configuration bit 3 is set, or on the cold reset output if it is clear. With bit 4 clear there is no pulse. Either way, the first stage then restarts.
- R8: In a guarded keep-alive write, bit 8 restarts the first stage from preload 1 and bit 9 clears the flag. If the flag is clear when the second stage expires, no reset is requested.
- R9: Configuration bit 2 shortens the unit to 2^FAST_LOG2 clocks.
- R10: Bit 1 of word 0x18 enables the timer. While it is clear, the count holds at preload 1 and the flag and notification pin do not change.
- R11: Bit 0 of word 0x18 is a lock. Once set, it stays set until reset, and writes to words 0x10 and 0x18 are ignored while the timer keeps running.
- R12: With the default PRE_W = 20 and UNIT_LOG2 = 15, the preload for 600 s at 33 MHz (604247) fits the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | 5 | Word-aligned register address |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte lane enables |
| rdata | output | 32 | Read data for addr, combinational |
| flag_o | output | 1 | First-stage timeout flag |
| notify_o | output | 1 | Pin that inverts on each first-stage expiry |
| warm_rst_o | output | 1 | Warm reset request pulse |
| cold_rst_o | output | 1 | Cold reset request pulse |

## Verification
The bench builds the block with UNIT_LOG2 = 3, FAST_LOG2 = 1, RST_LEN = 3 and the default 20-bit counter. At these values a full first stage, second stage and reset pulse take tens of clocks instead of seconds, so exact expiry edges and pulse lengths can be checked in both prescaler ranges. The 20-bit width is kept so that the 600 s preload and the masking of the upper preload bits are exercised as they would be in use. Random sequences of key bytes mixed with foreign writes check the key rules against a transaction-level model.

// File: rtl/lockwd_timer.sv
module lockwd_timer #(
  parameter int PRE_W     = 20,
  parameter int UNIT_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter int RST_LEN   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  input  logic [3:0]  wstrb,
  output logic [31:0] rdata,
  output logic        flag_o,
  output logic        notify_o,
  output logic        warm_rst_o,
  output logic        cold_rst_o
);
  localparam int PS_W = (UNIT_LOG2 < 1) ? 1 : UNIT_LOG2;
  localparam int RL_W = $clog2(RST_LEN + 1);
  localparam logic [PS_W-1:0] PS_SLOW = PS_W'((64'd1 << UNIT_LOG2) - 1);
  localparam logic [PS_W-1:0] PS_FAST = PS_W'((64'd1 << FAST_LOG2) - 1);
  localparam logic [4:0] A_PV1 = 5'h00, A_PV2 = 5'h04, A_KICK = 5'h0C,
                         A_CFG = 5'h10, A_CNT = 5'h14, A_CTL = 5'h18;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_t;

  key_t             key_q;
  logic [31:0]      pv1_q, pv2_q;
  logic [3:0]       cfg_q;   // {no_notify, rst_en, warm, fast}
  logic             lock_q, en_q;
  logic             stage_q, flag_q, notify_q, warm_sel_q;
  logic [PRE_W-1:0] cnt_q;
  logic [PS_W-1:0]  ps_q;
  logic [RL_W-1:0]  rcnt_q;

  function automatic logic [31:0] merge_bytes(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    for (int i = 0; i < 4; i++) merge_bytes[8*i +: 8] = be[i] ? nw[8*i +: 8] : old[8*i +: 8];
  endfunction

  wire key_wr  = wr_en && addr == A_KICK && wstrb[0] && !wstrb[1];
  wire kick_wr = wr_en && addr == A_KICK && wstrb[1];
  wire pv1_wr  = wr_en && addr == A_PV1 && |wstrb;
  wire pv2_wr  = wr_en && addr == A_PV2 && |wstrb;
  wire armed   = key_q == K_ARMED;
  wire cfg_wr  = wr_en && addr == A_CFG && wstrb[0] && !lock_q;
  wire ctl_wr  = wr_en && addr == A_CTL && wstrb[0] && !lock_q;
  wire kick    = armed && kick_wr && wdata[8];
  wire clr     = armed && kick_wr && wdata[9];

  wire [PS_W-1:0] ps_top = cfg_q[0] ? PS_FAST : PS_SLOW;
  wire            tick   = ps_q == '0;
  wire            expire = en_q && !kick && tick && cnt_q == '0;
  wire            fire   = expire && stage_q && flag_q && cfg_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) key_q <= K_IDLE;
    else if (wr_en) begin
      if (key_wr)
        key_q <= (wdata[7:0] == 8'h80) ? K_HALF :
                 (key_q == K_HALF && wdata[7:0] == 8'h86) ? K_ARMED : K_IDLE;
      else
        key_q <= K_IDLE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pv1_q <= '0; pv2_q <= '0; cfg_q <= '0; lock_q <= 1'b0; en_q <= 1'b0;
    end else begin
      if (armed && pv1_wr) pv1_q <= merge_bytes(pv1_q, wdata, wstrb);
      if (armed && pv2_wr) pv2_q <= merge_bytes(pv2_q, wdata, wstrb);
      if (cfg_wr) cfg_q <= wdata[5:2];
      if (ctl_wr) begin
        en_q   <= wdata[1];
        lock_q <= wdata[0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stage_q <= 1'b0; cnt_q <= '0; ps_q <= '0;
    end else if (!en_q || kick) begin
      stage_q <= 1'b0; cnt_q <= pv1_q[PRE_W-1:0]; ps_q <= ps_top;
    end else if (tick) begin
      ps_q <= ps_top;
      if (cnt_q == '0) begin
        stage_q <= ~stage_q;
        cnt_q   <= stage_q ? pv1_q[PRE_W-1:0] : pv2_q[PRE_W-1:0];
      end else cnt_q <= cnt_q - 1'b1;
    end else ps_q <= ps_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= 1'b0; notify_q <= 1'b0; rcnt_q <= '0; warm_sel_q <= 1'b0;
    end else begin
      if (expire && !stage_q) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (expire && !stage_q && !cfg_q[3]) notify_q <= ~notify_q;
      if (fire) begin
        rcnt_q <= RL_W'(RST_LEN); warm_sel_q <= cfg_q[1];
      end else if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
    end

  always_comb
    case (addr)
      A_PV1:   rdata = pv1_q;
      A_PV2:   rdata = pv2_q;
      A_KICK:  rdata = {22'd0, flag_q, 9'd0};
      A_CFG:   rdata = {26'd0, cfg_q, 2'b00};
      A_CNT:   rdata = 32'(cnt_q);
      A_CTL:   rdata = {30'd0, en_q, lock_q};
      default: rdata = '0;
    endcase

  assign flag_o     = flag_q;
  assign notify_o   = notify_q;
  assign warm_rst_o = rcnt_q != '0 && warm_sel_q;
  assign cold_rst_o = rcnt_q != '0 && !warm_sel_q;

  // R2
  pv1_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pv1_q) |-> $past(key_q) == K_ARMED);
  // R2
  pv2_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pv2_q) |-> $past(key_q) == K_ARMED);
  // R6
  notify_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(notify_q) |-> flag_q);
  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warm_rst_o || cold_rst_o) |-> $past(stage_q) && $past(flag_q));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(notify_q) && !$rose(flag_q));
  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q) && $stable(en_q));
endmodule

// File: tb/test_lockwd_timer.sv
`timescale 1ns/1ps
module test_lockwd_timer;
  localparam int PW = 20, UL = 3, FL = 1, RL = 3;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  wire [31:0] rdata;
  wire flag, notify, warm, cold;

  lockwd_timer #(.PRE_W(PW), .UNIT_LOG2(UL), .FAST_LOG2(FL), .RST_LEN(RL)) i_lockwd_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .wstrb(wstrb),
    .rdata(rdata), .flag_o(flag), .notify_o(notify), .warm_rst_o(warm), .cold_rst_o(cold));

  always #4 clk = ~clk;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int nchk = 0, nfail = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int unsigned stage_len(logic [31:0] pv, bit fast);
    return ((pv & 32'((1 << PW) - 1)) + 1) << (fast ? FL : UL);
  endfunction

  function automatic int key_next(int st, bit is_key, logic [7:0] d);
    if (!is_key) return 0;
    if (d == 8'h80) return 1;
    if (st == 1 && d == 8'h86) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] preload_for(longint secs);
    return 32'(((secs * 64'd33000000) >> 15) - 1);
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] s);
    addr = a; wdata = d; wstrb = s; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; wstrb = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic key();
    wr(5'h0C, 32'h80, 4'b0001);
    wr(5'h0C, 32'h86, 4'b0001);
  endtask

  task automatic wait_until(int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d, exp_pv1;
    int unsigned e, k, n, m;
    logic t0;
    void'($urandom(32'd4711));
    do_reset();

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(4 * a), d); chk("R1 register", d, 0);
    end
    chk("R1 outputs", {flag, notify, warm, cold}, 0);

    // R2 guarded writes
    wr(5'h00, 32'h5, 4'hF); rd(5'h00, d); chk("R2 no key", d, 0);
    key(); wr(5'h00, 32'h5, 4'hF); rd(5'h00, d); chk("R2 keyed", d, 5);
    // R3 key consumed
    key(); wr(5'h04, 32'h9, 4'hF); wr(5'h04, 32'hB, 4'hF); rd(5'h04, d); chk("R3 single use", d, 9);
    wr(5'h0C, 32'h80, 4'b0001); wr(5'h10, 32'h0, 4'b0001); wr(5'h0C, 32'h86, 4'b0001);
    wr(5'h00, 32'h7, 4'hF); rd(5'h00, d); chk("R3 interleaved write", d, 5);
    wr(5'h0C, 32'h80, 4'b0001); key(); wr(5'h00, 32'h7, 4'hF); rd(5'h00, d); chk("R3 restart key", d, 7);

    // R4 byte strobes and full readback
    key(); wr(5'h00, 32'h11223344, 4'b0100); rd(5'h00, d); chk("R4 byte lane", d, 32'h00220007);
    // R12 600 s preload fits
    chk("R12 range", preload_for(600) < (1 << PW), 1);
    key(); wr(5'h00, preload_for(600), 4'hF); rd(5'h00, d); chk("R12 readback", d, 32'd604247);

    // R3 random key sequences against model
    exp_pv1 = preload_for(600);
    for (int it = 0; it < 60; it++) begin
      int st = 0;
      int ops = $urandom % 4;
      logic [31:0] v = $urandom;
      for (int o = 0; o < ops; o++) begin
        int kind = $urandom % 4;
        logic [7:0] b = (kind == 0) ? 8'h80 : (kind == 1) ? 8'h86 : 8'($urandom);
        if (kind == 3) begin wr(5'h14, 32'h0, 4'hF); st = key_next(st, 0, 0); end
        else begin wr(5'h0C, 32'(b), 4'b0001); st = key_next(st, 1, b); end
      end
      wr(5'h00, v, 4'hF);
      if (st == 2) exp_pv1 = v;
      rd(5'h00, d); chk("R3 random key", d, exp_pv1);
    end

    key(); wr(5'h00, 32'd3, 4'hF);
    key(); wr(5'h04, 32'd2, 4'hF);
    n = stage_len(3, 0); m = stage_len(2, 0);

    // R5 R6 stage timing, R7 no pulse without enable bit
    wr(5'h18, 32'h2, 4'b0001); e = cyc;
    rd(5'h14, d); chk("R5 count at start", d, 3);
    wait_until(e + 8); rd(5'h14, d); chk("R5 count after one unit", d, 2);
    wait_until(e + n - 1); chk("R5 flag before expiry", flag, 0);
    wait_until(e + n); chk("R6 flag set", flag, 1); chk("R6 notify inverts", notify, 1);
    rd(5'h0C, d); chk("R6 flag readable", d[9], 1);
    rd(5'h14, d); chk("R6 second stage load", d, 2);
    wait_until(e + n + m); chk("R7 no pulse when disabled", {warm, cold}, 0);
    rd(5'h14, d); chk("R7 stage 1 restarts", d, 3);

    // R8 clear flag averts reset, R7 cold pulse
    wr(5'h18, 32'h0, 4'b0001); wr(5'h10, 32'h10, 4'b0001);
    key(); wr(5'h0C, 32'h200, 4'b0010); chk("R8 flag cleared", flag, 0);
    wr(5'h18, 32'h2, 4'b0001); e = cyc;
    wait_until(e + n); chk("R6 flag set again", flag, 1);
    key(); wr(5'h0C, 32'h200, 4'b0010); chk("R8 clear in stage 2", flag, 0);
    wait_until(e + n + m + 1); chk("R8 no reset when cleared", {warm, cold}, 0);
    wait_until(e + 2 * n + 2 * m - 1); chk("R7 before pulse", {warm, cold}, 0);
    wait_until(e + 2 * n + 2 * m); chk("R7 cold pulse", {warm, cold}, 2'b01);
    wait_until(e + 2 * n + 2 * m + RL - 1); chk("R7 pulse held", {warm, cold}, 2'b01);
    wait_until(e + 2 * n + 2 * m + RL); chk("R7 pulse length", {warm, cold}, 0);

    // R8 keep-alive, R6 no notify, R7 warm pulse
    wr(5'h18, 32'h0, 4'b0001); wr(5'h10, 32'h38, 4'b0001);
    wr(5'h18, 32'h2, 4'b0001); e = cyc; t0 = notify;
    wait_until(e + 10); key(); wr(5'h0C, 32'h300, 4'b0010); k = cyc;
    chk("R8 keep-alive clears flag", flag, 0);
    rd(5'h14, d); chk("R8 keep-alive reloads", d, 3);
    wait_until(k + n - 1); chk("R8 restarted stage", flag, 0);
    wait_until(k + n); chk("R8 expiry after restart", flag, 1); chk("R6 notify disabled", notify, t0);
    wait_until(k + n + m); chk("R7 warm pulse", {warm, cold}, 2'b10);

    // R9 fast prescaler
    wr(5'h18, 32'h0, 4'b0001); wr(5'h10, 32'h04, 4'b0001);
    key(); wr(5'h0C, 32'h200, 4'b0010);
    wr(5'h18, 32'h2, 4'b0001); e = cyc; n = stage_len(3, 1);
    wait_until(e + n - 1); chk("R9 fast before", flag, 0);
    wait_until(e + n); chk("R9 fast expiry", flag, 1);

    // R10 disabled timer holds
    wr(5'h18, 32'h0, 4'b0001); key(); wr(5'h0C, 32'h200, 4'b0010); t0 = notify;
    e = cyc; wait_until(e + 100);
    rd(5'h14, d); chk("R10 count held", d, 3);
    chk("R10 flag held", flag, 0); chk("R10 notify held", notify, t0);

    // R11 lock
    wr(5'h18, 32'h3, 4'b0001); e = cyc;
    wr(5'h18, 32'h0, 4'b0001); rd(5'h18, d); chk("R11 lock ignores disable", d, 3);
    wr(5'h10, 32'h38, 4'b0001); rd(5'h10, d); chk("R11 cfg frozen", d, 32'h04);
    wait_until(e + n); chk("R11 timer runs locked", flag, 1);
    do_reset(); rd(5'h18, d); chk("R11 reset clears lock", d, 0);

    // R5 R9 R4 random stage lengths with junk upper preload bits
    for (int it = 0; it < 6; it++) begin
      logic [31:0] v = {12'($urandom), 20'($urandom % 6)};
      bit f = 1'($urandom);
      wr(5'h18, 32'h0, 4'b0001); wr(5'h10, 32'(f) << 2, 4'b0001);
      key(); wr(5'h00, v, 4'hF); key(); wr(5'h0C, 32'h200, 4'b0010);
      wr(5'h18, 32'h2, 4'b0001); e = cyc; n = stage_len(v, f);
      wait_until(e + n - 1); chk("R5 random before expiry", flag, 0);
      wait_until(e + n); chk("R4 random expiry", flag, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule